// File: doc/BRIEF.md
# Folded Three-Operand Adder

This block produces the sum y(n) = a(n) + b(n) + c(n) of three unsigned sample streams with a single two-input adder. The adder has one register stage and is shared between the two additions of each sample. Each sample period is two clock cycles long, and each of those cycles is a time partition. In partition 0 the adder adds a and b. In partition 1 it adds c to the partial sum, which is taken straight from its own output register and fed back as the left operand.

A small controller counts the partitions. It steers two operand multiplexers and tells an output register when to load a finished sum. The three input streams must be held for both cycles of a sample period. The result is registered and held for a whole sample period, and a one-cycle valid strobe marks each new value.

Top module: `fold3_adder`

## Requirements
- R1: While `rst` is high on a clock edge, that edge sets `y_out` to 0, `y_valid` to 0, the partition to 0 and the adder register to 0.
- R2: Once reset is released, the partition alternates 0, 1, 0, 1 on successive clock edges, starting at 0 on the first edge after release.
- R3: `y_out` is W+2 bits wide and equals the exact sum a+b+c. Even the largest operands (all ones) do not overflow.
- R4: `a_in` and `b_in` are sampled only in partition 0, and `c_in` only in partition 1. Changing an input in the other partition has no effect on the result.
- R5: Count cycles from 0, starting with the first edge after reset release. The sum of the sample presented in cycles 2n and 2n+1 is loaded into `y_out` on the edge that ends cycle 2n+2, so it is visible from cycle 2n+3.
- R6: `y_valid` is a one-cycle pulse that follows each load of a new sum. It rises at most every second cycle and never before the first complete sum.
- R7: `y_out` holds its value during every cycle in which no new sum is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | First operand stream, held two cycles per sample |
| b_in | input | W | Second operand stream, held two cycles per sample |
| c_in | input | W | Third operand stream, held two cycles per sample |
| y_out | output | W+2 | Registered three-operand sum |
| y_valid | output | 1 | One-cycle strobe marking a newly loaded sum |

## Verification
The partial-sum assertions take for granted two things about the inputs: `a_in` and `b_in` are meaningful in the partition-0 cycle, and `c_in` in the partition-1 cycle, with every sample aligned to the partition that follows reset release.

The stimulus drives each sample starting on the first partition-0 cycle after reset. In the cycle where an input is not used, the stimulus often replaces it with random values. This keeps the stimulus within what the assertions assume, while showing that such changes leave the sums unaffected. The stimulus also includes directed all-zero and all-ones samples and a reset in the middle of a stream.

// File: rtl/fold3_pkg.sv
package fold3_pkg;

  typedef enum logic {
    PART_AB   = 1'b0,
    PART_FEED = 1'b1
  } part_e;

  function automatic logic [31:0] ext_width(input int w);
    return 32'(w + 2);
  endfunction

endpackage

// File: rtl/fold3_phase_ctrl.sv
module fold3_phase_ctrl
  import fold3_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  output part_e phase,
  output logic  primed,
  output logic  capture
);

  part_e phase_q;
  logic  primed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q  <= PART_AB;
      primed_q <= 1'b0;
    end else begin
      phase_q  <= (phase_q == PART_AB) ? PART_FEED : PART_AB;
      if (phase_q == PART_FEED) primed_q <= 1'b1;
    end
  end

  assign phase   = phase_q;
  assign primed  = primed_q;
  assign capture = primed_q && (phase_q == PART_AB);

endmodule

// File: rtl/fold3_operand_mux.sv
module fold3_operand_mux
  import fold3_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = W + 2
) (
  input  part_e         phase,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic [W-1:0]  c_in,
  input  logic [SW-1:0] feedback,
  output logic [SW-1:0] left_op,
  output logic [SW-1:0] top_op
);

  always_comb begin
    if (phase == PART_AB) begin
      left_op = SW'(a_in);
      top_op  = SW'(b_in);
    end else begin
      left_op = feedback;
      top_op  = SW'(c_in);
    end
  end

endmodule

// File: rtl/fold3_pipe_adder.sv
module fold3_pipe_adder #(
  parameter int SW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] left_op,
  input  logic [SW-1:0] top_op,
  output logic [SW-1:0] sum_q
);

  always_ff @(posedge clk) begin
    if (rst) sum_q <= '0;
    else     sum_q <= left_op + top_op;
  end

endmodule

// File: rtl/fold3_out_capture.sv
module fold3_out_capture #(
  parameter int SW = 18
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [SW-1:0] sum_in,
  output logic [SW-1:0] y_q,
  output logic          valid_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q     <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= capture;
      if (capture) y_q <= sum_in;
    end
  end

endmodule

// File: rtl/fold3_adder.sv
module fold3_adder
  import fold3_pkg::*;
#(
  parameter int W = 16,
  localparam int SW = int'(ext_width(W))
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  input  logic [W-1:0]  c_in,
  output logic [SW-1:0] y_out,
  output logic          y_valid
);

  part_e         phase_q;
  logic          primed_q;
  logic          capture_ev;
  logic [SW-1:0] left_op;
  logic [SW-1:0] top_op;
  logic [SW-1:0] pipe_q;

  fold3_phase_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase_q),
    .primed  (primed_q),
    .capture (capture_ev)
  );

  fold3_operand_mux #(.W(W), .SW(SW)) u_mux (
    .phase    (phase_q),
    .a_in     (a_in),
    .b_in     (b_in),
    .c_in     (c_in),
    .feedback (pipe_q),
    .left_op  (left_op),
    .top_op   (top_op)
  );

  fold3_pipe_adder #(.SW(SW)) u_add (
    .clk     (clk),
    .rst     (rst),
    .left_op (left_op),
    .top_op  (top_op),
    .sum_q   (pipe_q)
  );

  fold3_out_capture #(.SW(SW)) u_out (
    .clk     (clk),
    .rst     (rst),
    .capture (capture_ev),
    .sum_in  (pipe_q),
    .y_q     (y_out),
    .valid_q (y_valid)
  );

endmodule

// File: rtl/fold3_checker.sv
module fold3_checker #(
  parameter int W  = 16,
  parameter int SW = W + 2
) (
  input logic          clk,
  input logic          rst,
  input logic          phase,
  input logic          primed,
  input logic [SW-1:0] pipe_q,
  input logic [W-1:0]  a_in,
  input logic [W-1:0]  b_in,
  input logic [W-1:0]  c_in,
  input logic [SW-1:0] y_out,
  input logic          y_valid
);

  a_r2_phase_alternates: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (phase != $past(phase)));

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (y_out == '0 && !y_valid && phase == 1'b0 && pipe_q == '0));

  a_r4_first_partial: assert property (@(posedge clk) disable iff (rst)
    (phase == 1'b0) |=> (pipe_q == SW'($past(a_in)) + SW'($past(b_in))));

  a_r4_feedback_add: assert property (@(posedge clk) disable iff (rst)
    (phase == 1'b1) |=> (pipe_q == $past(pipe_q) + SW'($past(c_in))));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    y_valid |=> !y_valid);

  a_r6_valid_partition: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> (phase == 1'b1 && primed));

  a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
    !y_valid |-> $stable(y_out));

  a_r5_loads_sum: assert property (@(posedge clk) disable iff (rst)
    y_valid |-> (y_out == $past(pipe_q)));

endmodule

bind fold3_adder fold3_checker #(.W(W), .SW(SW)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .phase   (phase_q),
  .primed  (primed_q),
  .pipe_q  (pipe_q),
  .a_in    (a_in),
  .b_in    (b_in),
  .c_in    (c_in),
  .y_out   (y_out),
  .y_valid (y_valid)
);

// File: tb/test_fold3_adder.sv
`timescale 1ns/1ps
module test_fold3_adder;

  localparam int W  = 16;
  localparam int SW = W + 2;
  localparam int NS = 72;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  a_in = '0;
  logic [W-1:0]  b_in = '0;
  logic [W-1:0]  c_in = '0;
  logic [SW-1:0] y_out;
  logic          y_valid;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [W-1:0] av [NS];
  logic [W-1:0] bv [NS];
  logic [W-1:0] cv [NS];
  bit           garb [NS];

  always #2 clk = ~clk;

  fold3_adder #(.W(W)) i_fold3_adder (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .c_in(c_in),
    .y_out(y_out), .y_valid(y_valid)
  );

  function automatic longint ref_sum(input int k);
    longint s = 0;
    s += longint'(av[k]);
    s += longint'(cv[k]);
    s += longint'(bv[k]);
    return s;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // caller is at a negedge with rst low
  task automatic run_stream(input int base, input int cnt);
    for (int k = 0; k < cnt; k++) begin
      int n = base + k;
      if (k > 0) @(negedge clk);
      check("R6 no strobe on partition-0 cycle", longint'(y_valid), 0);
      if (k >= 2) check("R7 output held", longint'(y_out), ref_sum(n - 2));
      a_in = av[n];
      b_in = bv[n];
      c_in = garb[n] ? W'($urandom) : cv[n];       // R4: c ignored in partition 0
      @(posedge clk);
      @(negedge clk);
      check("R6 strobe after sum load", longint'(y_valid), (k >= 1) ? 1 : 0);
      if (k >= 1) check("R5 R3 sum value", longint'(y_out), ref_sum(n - 1));
      if (garb[n]) begin                           // R4: a, b ignored in partition 1
        a_in = W'($urandom);
        b_in = W'($urandom);
      end
      c_in = cv[n];
      @(posedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < NS; i++) begin
      av[i] = W'($urandom);
      bv[i] = W'($urandom);
      cv[i] = W'($urandom);
      garb[i] = ($urandom % 2) == 1;
    end
    av[0] = '0; bv[0] = '0; cv[0] = '0;
    av[1] = '1; bv[1] = '1; cv[1] = '1;            // R3 largest operands
    av[2] = '1; bv[2] = '0; cv[2] = '1;
    av[3] = 16'd1; bv[3] = 16'd2; cv[3] = 16'd3;
    garb[3] = 1'b1;
    av[4] = '1; bv[4] = '1; cv[4] = '1; garb[4] = 1'b1;

    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset output", longint'(y_out), 0);
    check("R1 reset strobe", longint'(y_valid), 0);
    rst = 1'b0;
    run_stream(0, 60);

    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1 mid-stream reset output", longint'(y_out), 0);
    check("R1 mid-stream reset strobe", longint'(y_valid), 0);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    run_stream(60, 12);                            // R2 partitions restart at 0

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule